// File: doc/BRIEF.md
# Undervoltage / Overvoltage Debounce Protection Controller

This block turns two digital comparator flags (input undervoltage and input overvoltage) into the switching permission for a power converter. Each flag is filtered by its own up/down counter. The counter climbs while the fault is reported and falls back toward zero while it is not. A brief glitch therefore drains away without any effect. Only a fault that builds the counter up to its end-of-count trips the protection.

An undervoltage trip latches the controller into a deep, low-power off state. Leaving that state takes a second, independent debounced condition: the supply must be reported healthy for long enough. An overvoltage trip stops switching for a fixed hold interval. After the hold, switching resumes only once the overvoltage flag has cleared. Every return to switching issues a one-cycle soft-start request.

All filter lengths and the hold interval are parameters counted in clock cycles. The defaults correspond to a 50 MHz clock: 30 ms, 30 ms, 250 µs and 500 ms.

Top module: `prot_debounce_ctrl`

## Requirements
- R1: While reset is held and after its release, `pwm_en_o`=1, `deep_off_o`=0 and `soft_start_o`=0, until a trip occurs.
- R2: The trip counter for undervoltage steps up on each cycle with `uv_flag_i`=1 (1 = supply below threshold). It steps down toward zero, without wrapping, on each cycle with `uv_flag_i`=0. After `UV_DEB_CYC` net up-steps it reaches end-of-count, and the outputs enter deep-off one cycle later. With a continuous fault, `deep_off_o` is first seen high `UV_DEB_CYC`+1 clock edges after the flag is first sampled high.
- R3: A counter that has not reached its end-of-count has no effect on the outputs. Down-steps cancel earlier up-steps, so a burst shorter than the limit that is followed by enough healthy cycles leaves switching enabled.
- R4: In deep-off, `pwm_en_o`=0 and `deep_off_o`=1. `ov_flag_i` is ignored in this state.
- R5: In deep-off, a separate recovery counter steps up on cycles with `uv_flag_i`=0 and down on cycles with `uv_flag_i`=1. At `UV_REST_CYC` net up-steps, switching resumes one cycle later with `deep_off_o`=0. The undervoltage trip counter restarts from zero after each trip.
- R6: The overvoltage counter steps up on cycles with `ov_flag_i`=1 (1 = above threshold) and down otherwise, and it counts only while switching is enabled. At `OV_DEB_CYC` net up-steps, `pwm_en_o` falls one cycle later while `deep_off_o` stays 0.
- R7: After an overvoltage trip, switching stays off for `OV_HOLD_CYC` cycles whatever `ov_flag_i` does.
- R8: After the hold interval, switching resumes on the edge after the first cycle in which `ov_flag_i`=0.
- R9: Undervoltage takes priority. If both counters reach end-of-count together, the block enters deep-off. An undervoltage trip during the overvoltage hold or wait also enters deep-off.
- R10: `soft_start_o` is a single-cycle pulse, raised in the first cycle of every return to `pwm_en_o`=1, and never at any other time.
- R11: `pwm_en_o` and `deep_off_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uv_flag_i | input | 1 | Undervoltage comparator output, 1 = below threshold |
| ov_flag_i | input | 1 | Overvoltage comparator output, 1 = above threshold |
| pwm_en_o | output | 1 | Switching permitted |
| deep_off_o | output | 1 | Latched low-power disable after undervoltage |
| soft_start_o | output | 1 | One-cycle soft-start request on re-enable |

## Verification
The assertions check several properties on every cycle:
- the two enable outputs are mutually exclusive;
- each soft-start pulse is one cycle wide and coincides exactly with a rising enable;
- every entry into deep-off is preceded by the undervoltage flag, and every overvoltage shutdown by the overvoltage flag;
- an overvoltage release never happens while the flag is still set, nor before the hold interval has elapsed.

Only the bench scenarios can show the following behaviours:
- the exact trip cycles;
- the cancelling effect of down-steps on partly filled counters;
- the recovery counter's up/down behaviour;
- undervoltage priority when both counters reach end-of-count together.

The bench checks each of these against a cycle-level model of the requirements.

// File: rtl/prot_debounce_pkg.sv
package prot_debounce_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_OV_HOLD = 2'd1,
    ST_OV_WAIT = 2'd2,
    ST_UV_OFF  = 2'd3
  } prot_state_e;
endpackage

// File: rtl/pd_updown_cnt.sv
// Saturating up/down filter; eoc_o is high while the count sits at LIMIT.
module pd_updown_cnt #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic up_i,
  output logic eoc_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)                  cnt_d = '0;
    else if (up_i && cnt_q != LIM) cnt_d = cnt_q + 1'b1;
    else if (!up_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign eoc_o = (cnt_q == LIM);
endmodule

// File: rtl/pd_hold_timer.sv
// Counts while run_i is high; done_o in the last of CYCLES cycles.
module pd_hold_timer #(
  parameter int unsigned CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/prot_debounce_ctrl.sv
module prot_debounce_ctrl
  import prot_debounce_pkg::*;
#(
  parameter int unsigned UV_DEB_CYC  = 1500000,
  parameter int unsigned UV_REST_CYC = 1500000,
  parameter int unsigned OV_DEB_CYC  = 12500,
  parameter int unsigned OV_HOLD_CYC = 25000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uv_flag_i,
  input  logic ov_flag_i,
  output logic pwm_en_o,
  output logic deep_off_o,
  output logic soft_start_o
);
  prot_state_e state_q, state_d;
  logic uv_eoc, rest_eoc, ov_eoc, hold_done;
  logic ss_q;

  pd_updown_cnt #(.LIMIT(UV_DEB_CYC)) u_uv_deb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i ((state_q == ST_UV_OFF) || uv_eoc),
    .up_i    (uv_flag_i),
    .eoc_o   (uv_eoc)
  );

  // recovery filter only lives in deep-off
  pd_updown_cnt #(.LIMIT(UV_REST_CYC)) u_uv_rest (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i ((state_q != ST_UV_OFF) || rest_eoc),
    .up_i    (!uv_flag_i),
    .eoc_o   (rest_eoc)
  );

  pd_updown_cnt #(.LIMIT(OV_DEB_CYC)) u_ov_deb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i ((state_q != ST_RUN) || ov_eoc),
    .up_i    (ov_flag_i),
    .eoc_o   (ov_eoc)
  );

  pd_hold_timer #(.CYCLES(OV_HOLD_CYC)) u_ov_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_OV_HOLD),
    .done_o (hold_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (uv_eoc)      state_d = ST_UV_OFF;   // undervoltage wins
        else if (ov_eoc) state_d = ST_OV_HOLD;
      end
      ST_OV_HOLD: begin
        if (uv_eoc)         state_d = ST_UV_OFF;
        else if (hold_done) state_d = ST_OV_WAIT;
      end
      ST_OV_WAIT: begin
        if (uv_eoc)          state_d = ST_UV_OFF;
        else if (!ov_flag_i) state_d = ST_RUN;
      end
      ST_UV_OFF: begin
        if (rest_eoc) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      ss_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ss_q    <= (state_q != ST_RUN) && (state_d == ST_RUN);
    end
  end

  assign pwm_en_o     = (state_q == ST_RUN);
  assign deep_off_o   = (state_q == ST_UV_OFF);
  assign soft_start_o = ss_q;
endmodule

// File: rtl/prot_debounce_chk.sv
module prot_debounce_chk #(
  parameter int unsigned OV_HOLD_CYC = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic uv_flag_i,
  input logic ov_flag_i,
  input logic pwm_en_o,
  input logic deep_off_o,
  input logic soft_start_o
);
  logic [31:0] off_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      off_cnt <= '0;
    else if (!pwm_en_o && !deep_off_o) off_cnt <= off_cnt + 1'b1;
    else                              off_cnt <= '0;
  end

  AST_RUN_DEEP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwm_en_o && deep_off_o)); // R11
  AST_SS_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_start_o |=> !soft_start_o); // R10
  AST_SS_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_start_o |-> (pwm_en_o && !$past(pwm_en_o))); // R10
  AST_RISE_HAS_SS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_en_o) |-> soft_start_o); // R10
  AST_DEEP_EXIT_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(deep_off_o) |-> pwm_en_o); // R5
  AST_DEEP_NEEDS_UV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(deep_off_o) |-> $past(uv_flag_i, 2)); // R2
  AST_OV_TRIP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pwm_en_o) && !deep_off_o) |-> $past(ov_flag_i, 2)); // R6
  AST_OV_RELEASE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pwm_en_o) && !$past(deep_off_o)) |-> !$past(ov_flag_i)); // R8
  AST_OV_HOLD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pwm_en_o) && !$past(deep_off_o)) |-> (off_cnt >= OV_HOLD_CYC)); // R7
endmodule

bind prot_debounce_ctrl prot_debounce_chk #(.OV_HOLD_CYC(OV_HOLD_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .uv_flag_i    (uv_flag_i),
  .ov_flag_i    (ov_flag_i),
  .pwm_en_o     (pwm_en_o),
  .deep_off_o   (deep_off_o),
  .soft_start_o (soft_start_o)
);

// File: tb/prot_debounce_ctrl_tb.sv
module prot_debounce_ctrl_tb;
  localparam int UVD = 20;
  localparam int UVR = 16;
  localparam int OVD = 6;
  localparam int OVH = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv_f = 1'b0;
  logic ov_f = 1'b0;
  logic pwm_en, deep_off, ss;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model state: 0 run, 1 hold, 2 wait, 3 deep-off
  int m_st = 0, m_uv = 0, m_rs = 0, m_ov = 0, m_hold = 0;
  bit m_ss = 0;

  always #10 clk = ~clk;

  prot_debounce_ctrl #(
    .UV_DEB_CYC(UVD), .UV_REST_CYC(UVR), .OV_DEB_CYC(OVD), .OV_HOLD_CYC(OVH)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .uv_flag_i(uv_f), .ov_flag_i(ov_f),
    .pwm_en_o(pwm_en), .deep_off_o(deep_off), .soft_start_o(ss)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int updn(input int c, input bit up, input int lim);
    if (up) return (c < lim) ? c + 1 : c;
    return (c > 0) ? c - 1 : 0;
  endfunction

  task automatic model_step(input bit uvf, input bit ovf);
    bit uv_e, rs_e, ov_e, hd;
    int nst;
    uv_e = (m_uv == UVD);
    rs_e = (m_rs == UVR);
    ov_e = (m_ov == OVD);
    hd   = (m_st == 1) && (m_hold == OVH - 1);
    nst  = m_st;
    case (m_st)
      0: if (uv_e) nst = 3; else if (ov_e) nst = 1;
      1: if (uv_e) nst = 3; else if (hd) nst = 2;
      2: if (uv_e) nst = 3; else if (!ovf) nst = 0;
      default: if (rs_e) nst = 0;
    endcase
    m_uv   = (m_st == 3 || uv_e) ? 0 : updn(m_uv, uvf, UVD);
    m_rs   = (m_st != 3 || rs_e) ? 0 : updn(m_rs, !uvf, UVR);
    m_ov   = (m_st != 0 || ov_e) ? 0 : updn(m_ov, ovf, OVD);
    m_hold = (m_st != 1) ? 0 : m_hold + 1;
    m_ss   = (m_st != 0) && (nst == 0);
    m_st   = nst;
  endtask

  // drive at negedge, model the coming edge, compare at next negedge
  task automatic cyc(input bit uvf, input bit ovf);
    uv_f = uvf;
    ov_f = ovf;
    model_step(uvf, ovf);
    @(negedge clk);
    chk("R6 pwm_en vs model", pwm_en, m_st == 0);
    chk("R4 deep_off vs model", deep_off, m_st == 3);
    chk("R10 soft_start vs model", ss, m_ss);
  endtask

  task automatic run(input int n, input bit uvf, input bit ovf);
    for (int i = 0; i < n; i++) cyc(uvf, ovf);
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    chk("R1 reset pwm_en", pwm_en, 1'b1);
    chk("R1 reset deep_off", deep_off, 1'b0);
    chk("R1 reset soft_start", ss, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    run(3, 0, 0);
    chk("R1 idle pwm_en", pwm_en, 1'b1);

    // R3: partial bursts cancelled by down-steps
    run(UVD - 1, 1, 0);
    run(UVD, 0, 0);
    chk("R3 uv glitch no trip", deep_off, 1'b0);
    run(OVD - 1, 0, 1);
    run(OVD, 0, 0);
    chk("R3 ov glitch no trip", pwm_en, 1'b1);
    run(10, 1, 0);
    run(4, 0, 0);
    run(UVD - 7, 1, 0);  // net UVD-1
    chk("R3 net count below limit", deep_off, 1'b0);

    // R2: trip one cycle after end-of-count
    run(1, 1, 0);        // net UVD
    chk("R2 at eoc still running", pwm_en, 1'b1);
    run(1, 1, 0);
    chk("R2 deep_off after eoc", deep_off, 1'b1);
    chk("R4 pwm_en low in deep-off", pwm_en, 1'b0);

    // R4: overvoltage ignored while deep-off
    run(OVD + 5, 1, 1);
    chk("R4 ov ignored pwm_en", pwm_en, 1'b0);
    chk("R4 ov ignored deep_off", deep_off, 1'b1);

    // R5: recovery counter with down-steps
    run(UVR - 1, 0, 0);
    run(3, 1, 0);
    run(3, 0, 0);        // net UVR-1
    chk("R5 recovery below limit", deep_off, 1'b1);
    run(1, 0, 0);        // net UVR
    chk("R5 at eoc still off", pwm_en, 1'b0);
    run(1, 0, 0);
    chk("R5 re-enabled", pwm_en, 1'b1);
    chk("R10 pulse on uv recovery", ss, 1'b1);
    run(1, 0, 0);
    chk("R10 pulse single cycle", ss, 1'b0);

    // R5: trip counter restarted from zero
    run(UVD, 1, 0);
    chk("R5 fresh count not tripped", deep_off, 1'b0);
    run(1, 1, 0);
    chk("R5 fresh count tripped", deep_off, 1'b1);
    run(UVR + 1, 0, 0);
    chk("R5 second recovery", pwm_en, 1'b1);

    // R6/R7/R8: overvoltage with flag clearing early
    run(OVD, 0, 1);
    chk("R6 at eoc still running", pwm_en, 1'b1);
    run(1, 0, 0);
    chk("R6 pwm off after eoc", pwm_en, 1'b0);
    chk("R6 deep_off stays low", deep_off, 1'b0);
    run(OVH - 1, 0, 0);
    chk("R7 still held", pwm_en, 1'b0);
    run(1, 0, 0);
    chk("R7 hold end waits one cycle", pwm_en, 1'b0);
    run(1, 0, 0);
    chk("R8 resumed after hold", pwm_en, 1'b1);
    chk("R10 pulse on ov recovery", ss, 1'b1);

    // R8: flag held through hold and beyond
    run(OVD + 1, 0, 1);
    chk("R6 second ov trip", pwm_en, 1'b0);
    run(OVH + 5, 0, 1);
    chk("R8 waits while flag set", pwm_en, 1'b0);
    run(1, 0, 0);
    chk("R8 resumes once clear", pwm_en, 1'b1);

    // R9: simultaneous end-of-count
    run(UVD - OVD, 1, 0);
    run(OVD, 1, 1);
    run(1, 1, 1);
    chk("R9 uv wins tie", deep_off, 1'b1);
    run(UVR + 1, 0, 0);
    chk("R9 recovered", pwm_en, 1'b1);

    // R9: undervoltage during overvoltage hold
    run(OVD + 1, 0, 1);
    run(UVD + 1, 1, 0);
    chk("R9 uv during ov hold", deep_off, 1'b1);
    run(UVR + 1, 0, 0);

    // random mix
    for (int s = 0; s < 2500; s++) begin
      int dur;
      bit u, o;
      dur = 1 + $urandom_range(0, 29);
      u = ($urandom_range(0, 3) == 0);
      o = ($urandom_range(0, 2) == 0);
      for (int k = 0; k < dur; k++) begin
        bit uu, oo;
        uu = ($urandom_range(0, 9) == 0) ? !u : u;
        oo = ($urandom_range(0, 9) == 0) ? !o : o;
        cyc(uu, oo);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule